// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor core. It fetches, decodes and completes one instruction on every rising clock edge. The supported instructions are five register-to-register operations (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and jump. Instruction storage and data storage are two separate arrays, so an instruction fetch and a data access can happen in the same cycle.

The core holds a 32-entry register file, an ALU, a sign extender, a main decoder with a second-level ALU decoder, and the steering multiplexers that connect them. While reset is held, a loader port writes words into either memory, so a program and its data can be placed before execution starts. Two inspection ports read any register and any data word. A third group of outputs shows the store strobe, address and data of the current cycle.

Top module: `onecycle_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register is cleared. Nothing executes during reset.
- R2: Any instruction other than a taken branch or a jump sets the PC to PC+4 at the edge that ends its cycle.
- R3: Opcode 0 is the register class. It writes field rd (bits [15:11]) with rs op rt, where rs is bits [25:21] and rt is bits [20:16]. The funct field (bits [5:0]) selects the operation: 32 add, 34 subtract, 36 and, 37 or, 42 set-less-than.
- R4: Register 0 always reads as 0. Writes to register 0 are discarded.
- R5: Opcode 35 (load) writes register rt with data word number (rs + sign-extended bits [15:0]) >> 2.
- R6: Opcode 43 (store) writes register rt to data word (rs + sign-extended immediate) >> 2. During that cycle `dm_we` is 1 and `dm_addr`/`dm_wdata` show the byte address and the data. No register is written.
- R7: Opcode 4 (branch-if-equal) sets the PC to PC+4+(sign-extended immediate << 2) when rs equals rt. Otherwise it sets the PC to PC+4.
- R8: Opcode 2 (jump) sets the PC to {PC[31:28], bits [25:0], 2'b00}.
- R9: Any other opcode writes no register and no memory, and advances the PC by 4.
- R10: Immediates are sign-extended. Negative load/store offsets and backward branch offsets work.
- R11: Set-less-than compares signed values and writes 1 or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Loader write strobe (used while in reset) |
| ld_imem | input | 1 | Loader target: 1 instruction memory, 0 data memory |
| ld_addr | input | LAW | Loader word index |
| ld_data | input | 32 | Loader word |
| pc | output | 32 | Current program counter |
| peek_reg_idx | input | 5 | Register number to inspect |
| peek_reg | output | 32 | Value of the inspected register |
| peek_mem_idx | input | DAW | Data word index to inspect |
| peek_mem | output | 32 | Value of the inspected data word |
| dm_we | output | 1 | Store happening this cycle |
| dm_addr | output | 32 | ALU result, used as the data byte address |
| dm_wdata | output | 32 | Store data (second register operand) |

## Verification
The embedded assertions check these properties on every cycle: the PC value right after reset, sequential PC advance for every non-control-flow instruction, the taken-branch and jump targets, register 0 staying zero, and the absence of a register write during a store. The following can only be shown by directed programs that read values back through the inspection ports: the arithmetic results, signed comparison, the load and store contents with negative offsets, the not-taken and backward branch paths, the retention of the upper PC bits across a jump, and the harmlessness of unknown opcodes.

// File: rtl/onecycle_core.sv
module onecycle_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic           ld_imem,
  input  logic [LAW-1:0] ld_addr,
  input  logic [31:0]    ld_data,
  output logic [31:0]    pc,
  input  logic [4:0]     peek_reg_idx,
  output logic [31:0]    peek_reg,
  input  logic [DAW-1:0] peek_mem_idx,
  output logic [31:0]    peek_mem,
  output logic           dm_we,
  output logic [31:0]    dm_addr,
  output logic [31:0]    dm_wdata
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  logic [31:0] instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, wa;
  logic [31:0] simm, rd1, rd2, op_a, op_b, a_in, b_in, sum, alu_y, wd, mem_rd;
  logic        is_r, is_lw, is_sw, is_beq, is_j;
  logic        rf_we, take_br, less;
  logic [1:0]  aluop;
  logic [3:0]  alu_ctl;
  logic [31:0] pc4, br_tgt, j_tgt, pc_nx;

  assign instr = imem[pc[IAW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign simm  = {{16{instr[15]}}, instr[15:0]};

  assign is_r   = op == 6'd0;
  assign is_lw  = op == 6'd35;
  assign is_sw  = op == 6'd43;
  assign is_beq = op == 6'd4;
  assign is_j   = op == 6'd2;
  assign aluop  = {is_r, is_beq};
  assign rf_we  = (is_r | is_lw) & ~rst;
  assign dm_we  = is_sw & ~rst;

  always_comb begin
    case (aluop)
      2'b00:   alu_ctl = 4'b0010;
      2'b01:   alu_ctl = 4'b0110;
      default:
        case (funct)
          6'd34:   alu_ctl = 4'b0110;
          6'd36:   alu_ctl = 4'b0000;
          6'd37:   alu_ctl = 4'b0001;
          6'd42:   alu_ctl = 4'b0111;
          default: alu_ctl = 4'b0010;
        endcase
    endcase
  end

  assign rd1  = rf[rs];
  assign rd2  = rf[rt];
  assign op_a = rd1;
  assign op_b = (is_lw | is_sw) ? simm : rd2;
  assign a_in = alu_ctl[3] ? ~op_a : op_a;
  assign b_in = alu_ctl[2] ? ~op_b : op_b;
  assign sum  = a_in + b_in + {31'd0, alu_ctl[2]};
  assign less = (op_a[31] != op_b[31]) ? op_a[31] : sum[31];

  always_comb begin
    case (alu_ctl[1:0])
      2'b00:   alu_y = a_in & b_in;
      2'b01:   alu_y = a_in | b_in;
      2'b10:   alu_y = sum;
      default: alu_y = {31'd0, less};
    endcase
  end

  assign mem_rd   = dmem[alu_y[DAW+1:2]];
  assign wa       = is_r ? rd : rt;
  assign wd       = is_lw ? mem_rd : alu_y;
  assign dm_addr  = alu_y;
  assign dm_wdata = rd2;

  assign pc4     = pc + 32'd4;
  assign br_tgt  = pc4 + {simm[29:0], 2'b00};
  assign j_tgt   = {pc[31:28], instr[25:0], 2'b00};
  assign take_br = is_beq & (alu_y == 32'd0);
  assign pc_nx   = is_j ? j_tgt : (take_br ? br_tgt : pc4);

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (rf_we && wa != 5'd0) begin
      rf[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_imem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_imem) dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (dm_we)        dmem[alu_y[DAW+1:2]] <= rd2;
  end

  assign peek_reg = rf[peek_reg_idx];
  assign peek_mem = dmem[peek_mem_idx];

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);
  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_beq && !is_j) |=> pc == $past(pc) + 32'd4);
  // R7
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (is_beq && rd1 == rd2) |=> pc == $past(pc) + 32'd4 + {$past(simm[29:0]), 2'b00});
  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    is_j |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});
  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst) rf[0] == 32'd0);
  // R6
  store_nowr_chk: assert property (@(posedge clk) disable iff (rst) dm_we |-> !rf_we);
endmodule

// File: tb/sim_onecycle_core.sv
`timescale 1ns/1ps
module sim_onecycle_core;
  localparam int LAW = 6, DAW = 6;
  logic clk = 0, rst = 1, ld_en = 0, ld_imem = 0;
  logic [LAW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc, peek_reg, peek_mem, dm_addr, dm_wdata;
  logic [4:0] peek_reg_idx = '0;
  logic [DAW-1:0] peek_mem_idx = '0;
  logic dm_we;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  onecycle_core u0 (.clk, .rst, .ld_en, .ld_imem, .ld_addr, .ld_data, .pc,
    .peek_reg_idx, .peek_reg, .peek_mem_idx, .peek_mem, .dm_we, .dm_addr, .dm_wdata);

  function automatic logic [31:0] r_ins(int s, int t, int d, int f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
  endfunction
  function automatic logic [31:0] i_ins(int o, int s, int t, int imm);
    return {6'(o), 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_ins(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] reg_of(int i);
    return 32'd0;
  endfunction

  task automatic rd_reg(int i, output logic [31:0] v);
    peek_reg_idx = 5'(i); #0.5; v = peek_reg;
  endtask
  task automatic rd_mem(int i, output logic [31:0] v);
    peek_mem_idx = DAW'(i); #0.5; v = peek_mem;
  endtask
  task automatic chk_reg(string tag, int i, logic [31:0] exp);
    logic [31:0] v; rd_reg(i, v); chk(tag, v, exp);
  endtask

  task automatic put(bit im, int a, logic [31:0] d);
    @(negedge clk); ld_en = 1; ld_imem = im; ld_addr = LAW'(a); ld_data = d;
  endtask
  task automatic clear_all();
    rst = 1;
    for (int a = 0; a < 64; a++) put(1, a, 32'd0);
    for (int a = 0; a < 64; a++) put(0, a, 32'd0);
  endtask
  task automatic go();
    @(negedge clk); ld_en = 0; rst = 0;
  endtask
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_all();
    @(negedge clk); ld_en = 0;
    step(1);
    chk("R1 pc in reset", pc, 32'd0);
    chk_reg("R1 reg cleared", 7, 32'd0);
  endtask

  task automatic t_alu();
    logic [31:0] a = 32'd100, b = 32'hFFFF_FFF9, c = 32'h0F0F_0F0F;
    clear_all();
    put(0, 0, a); put(0, 1, b); put(0, 2, c);
    put(1, 0, i_ins(35, 0, 1, 0));
    put(1, 1, i_ins(35, 0, 2, 4));
    put(1, 2, i_ins(35, 0, 3, 8));
    put(1, 3, r_ins(1, 2, 4, 32));
    put(1, 4, r_ins(1, 2, 5, 34));
    put(1, 5, r_ins(1, 3, 6, 36));
    put(1, 6, r_ins(1, 3, 7, 37));
    put(1, 7, r_ins(2, 1, 8, 42));
    put(1, 8, r_ins(1, 2, 9, 42));
    go();
    step(1);
    chk("R2 pc after one", pc, 32'd4);
    step(8);
    chk("R2 pc after nine", pc, 32'd36);
    chk_reg("R5 load", 3, c);
    chk_reg("R3 add", 4, a + b);
    chk_reg("R3 sub", 5, a - b);
    chk_reg("R3 and", 6, a & c);
    chk_reg("R3 or", 7, a | c);
    chk_reg("R11 slt neg<pos", 8, 32'd1);
    chk_reg("R11 slt pos<neg", 9, 32'd0);
  endtask

  task automatic t_zero();
    clear_all();
    put(0, 0, 32'd55);
    put(1, 0, i_ins(35, 0, 1, 0));
    put(1, 1, r_ins(1, 1, 0, 32));
    put(1, 2, r_ins(0, 0, 10, 32));
    go();
    step(3);
    chk_reg("R4 r0 reads zero", 0, 32'd0);
    chk_reg("R4 r0 source zero", 10, 32'd0);
  endtask

  task automatic t_mem();
    logic [31:0] v;
    clear_all();
    put(0, 1, 32'd20); put(0, 3, 32'h0000_00AB);
    put(1, 0, i_ins(35, 0, 2, 12));
    put(1, 1, i_ins(35, 0, 4, 4));
    put(1, 2, i_ins(43, 4, 2, -4));
    put(1, 3, i_ins(35, 4, 5, -8));
    go();
    step(2);
    chk("R6 store strobe", {31'd0, dm_we}, 32'd1);
    chk("R10 store addr", dm_addr, 32'd16);
    chk("R6 store data", dm_wdata, 32'h0000_00AB);
    step(2);
    rd_mem(4, v);
    chk("R6 mem written", v, 32'h0000_00AB);
    chk_reg("R10 load neg offset", 5, 32'h0000_00AB);
    chk_reg("R6 no reg write", 31, 32'd0);
  endtask

  task automatic t_branch();
    clear_all();
    put(0, 0, 32'd5); put(0, 1, 32'd5); put(0, 2, 32'd6);
    put(1, 0, i_ins(35, 0, 1, 0));
    put(1, 1, i_ins(35, 0, 2, 4));
    put(1, 2, i_ins(35, 0, 3, 8));
    put(1, 3, i_ins(4, 1, 2, 2));
    put(1, 4, i_ins(35, 0, 10, 0));
    put(1, 5, i_ins(35, 0, 11, 0));
    put(1, 6, i_ins(4, 1, 3, 1));
    put(1, 7, i_ins(35, 0, 12, 0));
    put(1, 8, i_ins(4, 0, 0, -4));
    go();
    step(4);
    chk("R7 taken", pc, 32'd24);
    step(1);
    chk("R7 not taken", pc, 32'd28);
    step(2);
    chk("R10 backward branch", pc, 32'd20);
    chk_reg("R7 skipped slot", 10, 32'd0);
    step(1);
    chk_reg("R10 reentered slot", 11, 32'd5);
  endtask

  task automatic t_jump();
    clear_all();
    put(1, 0, j_ins(2));
    put(1, 2, j_ins(26'h3FF_FFFF));
    go();
    step(1);
    chk("R8 jump", pc, 32'd8);
    step(1);
    chk("R8 jump far", pc, 32'h0FFF_FFFC);
    step(1);
    chk("R2 carry into top", pc, 32'h1000_0000);
    step(1);
    chk("R8 keeps top bits", pc, 32'h1000_0008);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    int we_seen = 0;
    clear_all();
    put(0, 0, 32'h1234_5678);
    put(1, 0, i_ins(35, 0, 1, 0));
    put(1, 1, 32'hFFFF_FFFF);
    put(1, 2, i_ins(13, 1, 2, 0));
    go();
    step(1);
    for (int k = 0; k < 2; k++) begin
      if (dm_we) we_seen++;
      step(1);
    end
    chk("R9 pc advance", pc, 32'd12);
    chk("R9 no store strobe", 32'(we_seen), 32'd0);
    chk_reg("R9 rt untouched", 2, 32'd0);
    chk_reg("R9 r31 untouched", 31, 32'd0);
    chk_reg("R9 r1 kept", 1, 32'h1234_5678);
    rd_mem(0, v);
    chk("R9 mem kept", v, 32'h1234_5678);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_zero();
    t_mem();
    t_branch();
    t_jump();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule